// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Inverted-Borrow Carry

This block is the purely combinational arithmetic and logic unit of a small accumulator-based processor core. Each cycle it takes the accumulator value, a second operand (from data memory or an immediate field), the current carry and half-carry flags, and a four-bit operation code. It returns an eight-bit result and, for multiply, a separate upper product byte. It also returns new carry, half-carry and zero flag values, each paired with a write enable that tells the surrounding core whether that flag is updated.

Subtraction follows the inverted-borrow convention. A carry of one after a subtract means that no borrow occurred. Subtract-with-borrow therefore removes the complement of the incoming carry. Multiply places the low product byte on the main result and the high byte on a dedicated output, and the zero flag looks only at the low byte. Operand fetch, instruction decode, register storage and the choice of writeback destination belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives `res_o = (acc_i + opd_i) mod 256`. `c_o` is 1 exactly when the sum exceeds 255, and `c_we_o` is 1.
- R2: Operation code 1 (add with carry) gives `res_o = (acc_i + opd_i + c_i) mod 256`. `c_o` is 1 exactly when that sum exceeds 255, and `c_we_o` is 1.
- R3: Operation code 2 (subtract) gives `res_o = (acc_i - opd_i) mod 256`. `c_o` is 1 when `acc_i >= opd_i` (no borrow) and 0 otherwise, and `c_we_o` is 1.
- R4: Operation code 3 (subtract with borrow) gives `res_o = (acc_i - opd_i - (1 - c_i)) mod 256`. `c_o` is 1 exactly when no borrow occurs, and `c_we_o` is 1.
- R5: Operation code 11 (multiply) puts the low byte of `acc_i * opd_i` on `res_o` and the high byte on `hi_o`, with `hi_we_o` at 1. `z_o` is 1 only when the low byte is zero. The carry and half-carry enables are 0. For every other code `hi_we_o` is 0 and `hi_o` is 0.
- R6: Operation code 7 (nibble swap) gives `res_o = {acc_i[3:0], acc_i[7:4]}` and raises no flag write enable.
- R7: Operation code 8 (rotate right through carry) gives `res_o = {c_i, acc_i[7:1]}` and `c_o = acc_i[0]`. Operation code 9 (rotate left through carry) gives `res_o = {acc_i[6:0], c_i}` and `c_o = acc_i[7]`. Both raise `c_we_o` and leave `dc_we_o` at 0.
- R8: Operation codes 4, 5 and 6 give the bitwise AND, OR and XOR of the operands. For these codes `c_we_o` and `dc_we_o` are 0.
- R9: Operation code 10 (decimal adjust) adds 0x06 when `acc_i[3:0] > 9` or `dc_i` is 1. It adds 0x60 when `acc_i > 0x99` or `c_i` is 1. `c_o` is 1 exactly when the 0x60 correction applies.
- R10: The half-carry `dc_o` is the carry out of bit 3, with the same polarity as `c_o`, so that for subtracts 1 means no borrow from the low nibble. For decimal adjust it is the carry out of bit 3 of `acc_i[3:0]` plus the low correction. `dc_we_o` is 1 only for codes 0, 1, 2, 3 and 10.
- R11: Whenever `z_we_o` is 1, `z_o` equals 1 exactly when `res_o` is zero. `z_we_o` is 1 for every code from 0 to 11 except 7.
- R12: Codes 12 to 15 are no-operations: `res_o = acc_i` and every write enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Memory or immediate operand |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current half-carry flag |
| res_o | output | 8 | Main result byte |
| hi_o | output | 8 | High product byte for multiply |
| hi_we_o | output | 1 | High product byte valid |
| c_o | output | 1 | New carry value |
| c_we_o | output | 1 | Carry write enable |
| dc_o | output | 1 | New half-carry value |
| dc_we_o | output | 1 | Half-carry write enable |
| z_o | output | 1 | New zero flag value |
| z_we_o | output | 1 | Zero flag write enable |

## Verification
The bound checks assume that all inputs are two-valued and stable whenever they are evaluated, because the block has no clock and the checks fire on every input change. The bench changes inputs only on the rising edge of its own clock and compares results half a period later. Random operands cover every code, including the unused ones, with the flag inputs drawn freely. Directed vectors add the carry-out, borrow, zero-product and decimal-correction edges.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int unsigned DW  = 8;
    localparam int unsigned OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SWAP = 4'd7,
        OP_RRC  = 4'd8,
        OP_RLC  = 4'd9,
        OP_DAA  = 4'd10,
        OP_MUL  = 4'd11
    } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hcout_o
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] b_eff;
    logic [H-1:0] low_sum;

    // Subtraction as a + ~b + cin: carry out then means "no borrow".
    assign b_eff = sub_i ? ~b_i : b_i;

    assign {cout_o, sum_o}    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    assign {hcout_o, low_sum} = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]}
                              + {{H{1'b0}}, cin_i};
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    output logic [W-1:0] swap_o,
    output logic [W-1:0] rr_o,
    output logic         rr_c_o,
    output logic [W-1:0] rl_o,
    output logic         rl_c_o
);
    localparam int unsigned H = W / 2;

    assign swap_o = {a_i[H-1:0], a_i[W-1:H]};
    // Nine-bit rotations with the carry as the extra bit.
    assign rr_o   = {c_i, a_i[W-1:1]};
    assign rr_c_o = a_i[0];
    assign rl_o   = {a_i[W-2:0], c_i};
    assign rl_c_o = a_i[W-1];
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         dc_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         dc_o
);
    localparam int unsigned H = W / 2;
    localparam logic [H-1:0] NINE = H'(9);
    localparam logic [H-1:0] SIX  = H'(6);

    logic         fix_lo;
    logic         fix_hi;
    logic [H-1:0] lo_corr;
    logic [H-1:0] hi_corr;
    logic [H-1:0] lo_sum;

    assign fix_lo  = (a_i[H-1:0] > NINE) || dc_i;
    assign fix_hi  = (a_i > {NINE, NINE}) || c_i;
    assign lo_corr = fix_lo ? SIX : '0;
    assign hi_corr = fix_hi ? SIX : '0;

    assign res_o          = a_i + {hi_corr, lo_corr};
    assign c_o            = fix_hi;
    assign {dc_o, lo_sum} = {1'b0, a_i[H-1:0]} + {1'b0, lo_corr};
endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    logic [2*W-1:0] prod;

    assign prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign lo_o = prod[W-1:0];
    assign hi_o = prod[2*W-1:W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   acc_i,
    input  logic [W-1:0]   opd_i,
    input  logic           c_i,
    input  logic           dc_i,
    output logic [W-1:0]   res_o,
    output logic [W-1:0]   hi_o,
    output logic           hi_we_o,
    output logic           c_o,
    output logic           c_we_o,
    output logic           dc_o,
    output logic           dc_we_o,
    output logic           z_o,
    output logic           z_we_o
);
    alu_op_e      op;
    logic         as_sub;
    logic         as_cin;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_hc;
    logic [W-1:0] bo_swap;
    logic [W-1:0] bo_rr;
    logic         bo_rr_c;
    logic [W-1:0] bo_rl;
    logic         bo_rl_c;
    logic [W-1:0] da_res;
    logic         da_c;
    logic         da_dc;
    logic [W-1:0] mu_lo;
    logic [W-1:0] mu_hi;

    assign op = alu_op_e'(op_i);

    // Carry-in selection: plain subtract injects the +1 of two's complement,
    // subtract-with-borrow injects C itself (borrow is NOT C).
    always_comb begin
        as_sub = 1'b0;
        as_cin = 1'b0;
        unique case (op)
            OP_ADC:  as_cin = c_i;
            OP_SUB:  begin as_sub = 1'b1; as_cin = 1'b1; end
            OP_SBC:  begin as_sub = 1'b1; as_cin = c_i;  end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) i_addsub (
        .a_i(acc_i), .b_i(opd_i), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .cout_o(as_c), .hcout_o(as_hc)
    );

    alu8_bitops #(.W(W)) i_bitops (
        .a_i(acc_i), .c_i(c_i), .swap_o(bo_swap),
        .rr_o(bo_rr), .rr_c_o(bo_rr_c), .rl_o(bo_rl), .rl_c_o(bo_rl_c)
    );

    alu8_decadj #(.W(W)) i_decadj (
        .a_i(acc_i), .c_i(c_i), .dc_i(dc_i),
        .res_o(da_res), .c_o(da_c), .dc_o(da_dc)
    );

    alu8_mult #(.W(W)) i_mult (
        .a_i(acc_i), .b_i(opd_i), .lo_o(mu_lo), .hi_o(mu_hi)
    );

    // Result and flag value selection.
    always_comb begin
        res_o = acc_i;
        hi_o  = '0;
        c_o   = c_i;
        dc_o  = dc_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_o = as_sum;
                c_o   = as_c;
                dc_o  = as_hc;
            end
            OP_AND:  res_o = acc_i & opd_i;
            OP_OR:   res_o = acc_i | opd_i;
            OP_XOR:  res_o = acc_i ^ opd_i;
            OP_SWAP: res_o = bo_swap;
            OP_RRC:  begin res_o = bo_rr; c_o = bo_rr_c; end
            OP_RLC:  begin res_o = bo_rl; c_o = bo_rl_c; end
            OP_DAA:  begin res_o = da_res; c_o = da_c; dc_o = da_dc; end
            OP_MUL:  begin res_o = mu_lo; hi_o = mu_hi; end
            default: ;
        endcase
    end

    // Write-enable selection.
    always_comb begin
        hi_we_o = 1'b0;
        c_we_o  = 1'b0;
        dc_we_o = 1'b0;
        z_we_o  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DAA: begin
                c_we_o  = 1'b1;
                dc_we_o = 1'b1;
                z_we_o  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: z_we_o = 1'b1;
            OP_RRC, OP_RLC: begin
                c_we_o = 1'b1;
                z_we_o = 1'b1;
            end
            OP_MUL: begin
                hi_we_o = 1'b1;
                z_we_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign z_o = ~|res_o;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   acc_i,
    input logic [W-1:0]   opd_i,
    input logic           c_i,
    input logic           dc_i,
    input logic [W-1:0]   res_o,
    input logic [W-1:0]   hi_o,
    input logic           hi_we_o,
    input logic           c_o,
    input logic           c_we_o,
    input logic           dc_o,
    input logic           dc_we_o,
    input logic           z_o,
    input logic           z_we_o
);
    localparam int unsigned H = W / 2;

    always_comb begin
        if (op_i == OP_ADD) begin
            p_add_sum_r1: assert ({c_o, res_o} == {1'b0, acc_i} + {1'b0, opd_i});
        end
        if (op_i == OP_SUB) begin
            p_sub_noborrow_r3: assert (c_o == (acc_i >= opd_i));
        end
        if (op_i == OP_MUL) begin
            p_mul_split_r5: assert ({hi_o, res_o} == {{W{1'b0}}, acc_i} * {{W{1'b0}}, opd_i}
                                    && hi_we_o);
        end
        if (op_i == OP_SWAP) begin
            p_swap_quiet_r6: assert (!c_we_o && !dc_we_o && !z_we_o
                                     && res_o == {acc_i[H-1:0], acc_i[W-1:H]});
        end
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
            p_logic_keeps_c_r8: assert (!c_we_o && !dc_we_o);
        end
        if (z_we_o) begin
            p_zero_match_r11: assert (z_o == (res_o == '0));
        end
        if (op_i > OP_MUL) begin
            p_nop_pass_r12: assert (res_o == acc_i && !c_we_o && !dc_we_o
                                    && !z_we_o && !hi_we_o);
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) i_chk (.*);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op;
    logic [7:0] acc;
    logic [7:0] opd;
    logic       ci;
    logic       dci;
    logic [7:0] res;
    logic [7:0] hi;
    logic       hi_we, c, c_we, dc, dc_we, z, z_we;
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .op_i(op), .acc_i(acc), .opd_i(opd), .c_i(ci), .dc_i(dci),
        .res_o(res), .hi_o(hi), .hi_we_o(hi_we), .c_o(c), .c_we_o(c_we),
        .dc_o(dc), .dc_we_o(dc_we), .z_o(z), .z_we_o(z_we)
    );

    function automatic string tag(input int o);
        case (o)
            0: return "R1";   1: return "R2";   2: return "R3";   3: return "R4";
            4, 5, 6: return "R8";  7: return "R6";  8, 9: return "R7";
            10: return "R9";  11: return "R5";
            default: return "R12";
        endcase
    endfunction

    // Expected values from the requirement text, in plain integer arithmetic.
    task automatic model(input int o, input int a, input int b, input int cv, input int dv,
                         output int e_res, output int e_hi, output int e_hw,
                         output int e_cw, output int e_c, output int e_dw, output int e_dc,
                         output int e_zw);
        int bw;
        int lo;
        int hh;
        e_res = a; e_hi = 0; e_hw = 0; e_cw = 0; e_c = 0; e_dw = 0; e_dc = 0; e_zw = 0;
        case (o)
            0: begin e_res = (a + b) % 256; e_c = int'(a + b > 255);
                     e_dc = int'((a % 16) + (b % 16) > 15); e_cw = 1; e_dw = 1; e_zw = 1; end
            1: begin e_res = (a + b + cv) % 256; e_c = int'(a + b + cv > 255);
                     e_dc = int'((a % 16) + (b % 16) + cv > 15); e_cw = 1; e_dw = 1; e_zw = 1; end
            2: begin e_res = (a - b + 256) % 256; e_c = int'(a >= b);
                     e_dc = int'((a % 16) >= (b % 16)); e_cw = 1; e_dw = 1; e_zw = 1; end
            3: begin bw = 1 - cv; e_res = (a - b - bw + 512) % 256; e_c = int'(a >= b + bw);
                     e_dc = int'((a % 16) >= (b % 16) + bw); e_cw = 1; e_dw = 1; e_zw = 1; end
            4: begin e_res = a & b; e_zw = 1; end
            5: begin e_res = a | b; e_zw = 1; end
            6: begin e_res = a ^ b; e_zw = 1; end
            7: e_res = (a % 16) * 16 + a / 16;
            8: begin e_res = cv * 128 + a / 2; e_c = a % 2; e_cw = 1; e_zw = 1; end
            9: begin e_res = (a * 2) % 256 + cv; e_c = a / 128; e_cw = 1; e_zw = 1; end
            10: begin lo = int'((a % 16) > 9 || dv == 1); hh = int'(a > 153 || cv == 1);
                      e_res = (a + 6 * lo + 96 * hh) % 256; e_c = hh;
                      e_dc = int'((a % 16) + 6 * lo > 15); e_cw = 1; e_dw = 1; e_zw = 1; end
            11: begin e_res = (a * b) % 256; e_hi = (a * b) / 256; e_hw = 1; e_zw = 1; end
            default: ;
        endcase
    endtask

    task automatic cmp(input string t, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    task automatic apply(input int o, input int a, input int b, input int cv, input int dv);
        int e_res, e_hi, e_hw, e_cw, e_c, e_dw, e_dc, e_zw;
        string t;
        @(posedge clk);
        op = 4'(o); acc = 8'(a); opd = 8'(b); ci = 1'(cv); dci = 1'(dv);
        @(negedge clk);
        model(o, a, b, cv, dv, e_res, e_hi, e_hw, e_cw, e_c, e_dw, e_dc, e_zw);
        t = tag(o);
        cmp(t, "res", int'(res), e_res);
        cmp(t, "hi (R5)", int'(hi), e_hi);
        cmp(t, "hi_we (R5)", int'(hi_we), e_hw);
        cmp(t, "c_we", int'(c_we), e_cw);
        if (e_cw == 1) cmp(t, "c", int'(c), e_c);
        cmp(t, "dc_we (R10)", int'(dc_we), e_dw);
        if (e_dw == 1) cmp(t, "dc (R10)", int'(dc), e_dc);
        cmp(t, "z_we (R11)", int'(z_we), e_zw);
        if (e_zw == 1) cmp(t, "z (R11)", int'(z), int'(e_res == 0));
    endtask

    initial begin
        op = 4'hF; acc = '0; opd = '0; ci = 1'b0; dci = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: pass-through code with zero inputs, no writes (R12)
        cmp("R12", "reset res", int'(res), 0);
        cmp("R12", "reset enables", int'({hi_we, c_we, dc_we, z_we}), 0);
        rst_n = 1'b1;

        apply(0, 8'hFF, 8'h01, 0, 0);   // R1 carry out, zero result
        apply(0, 8'h0F, 8'h01, 0, 0);   // R10 half carry on add
        apply(1, 8'hFF, 8'h00, 1, 0);   // R2 carry-in wraps
        apply(1, 8'h7F, 8'h80, 0, 0);   // R2 no carry
        apply(2, 8'h00, 8'h01, 0, 0);   // R3 borrow -> C=0
        apply(2, 8'h55, 8'h55, 0, 0);   // R3 equal -> C=1, Z=1
        apply(3, 8'h10, 8'h10, 0, 0);   // R4 borrow consumed
        apply(3, 8'h10, 8'h10, 1, 0);   // R4 no borrow in
        apply(11, 8'h10, 8'h10, 0, 0);  // R5 low byte zero, high 0x01
        apply(11, 8'hFF, 8'hFF, 0, 0);  // R5 largest product
        apply(7, 8'hA5, 8'h00, 1, 1);   // R6
        apply(8, 8'h01, 8'h00, 0, 0);   // R7 rotate right to zero
        apply(9, 8'h80, 8'h00, 1, 0);   // R7 rotate left with carry in
        apply(4, 8'hF0, 8'h0F, 1, 1);   // R8 AND to zero
        apply(10, 8'h9A, 8'h00, 0, 0);  // R9 both corrections
        apply(10, 8'h12, 8'h00, 0, 1);  // R9 low correction via DC
        apply(10, 8'h45, 8'h00, 1, 0);  // R9 high correction via C
        apply(13, 8'h3C, 8'hFF, 1, 1);  // R12 unused code

        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            apply(int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
                  int'($urandom_range(255, 0)), int'($urandom_range(1, 0)),
                  int'($urandom_range(1, 0)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #200_000ns;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule